// File: doc/BRIEF.md
# Register write-pending hazard scoreboard

The block keeps one pending-write bit for each architectural register of a single register file. A 1 means that an issued instruction will write that register and the write has not landed yet. Each write-port lane does two things. It raises the bit for the destination it captured at issue. It drops the bit when the register file port writes that address, or when the unit completes without producing data. Read-check lanes ask whether a source register still has a write outstanding. Each write lane also reports a write-after-write conflict for the destination that is being presented for issue.

Set requests from all write lanes are ORed into one vector, and clear requests into another, before they update the state. No lane can mask another lane's request. The set path is registered, so it lands one cycle after issue. As a result, an instruction that reads and writes the same register never sees a hazard against itself. Register numbers are binary-coded by default. With `UNARY` set, the number port already holds the one-hot mask.

Top module: `wpsb_scoreboard`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, `vec_o` is all zero and every hazard output is low.
- R2: `issue_i[p]` with `wr_flag_i[p]` high in cycle T sets bit `dest_i[p]` (binary: mask is 1 shifted left by the number). The bit is visible on `vec_o` from cycle T+2 and is still clear in cycle T+1.
- R3: An issue with `wr_flag_i[p]` low sets no bit.
- R4: `wr_en_i[p]` in cycle T clears bit `wr_addr_i[p]`, visible from cycle T+1.
- R5: If lane p was issued with its write flag high and is still busy, then `done_i[p]` with `data_ok_i[p]` low clears the captured destination bit. `done_i[p]` with `data_ok_i[p]` high clears nothing by itself.
- R6: The captured write flag is dropped in any cycle in which `busy_i[p]` is low and no issue occurs. A later data-less `done_i[p]` then clears nothing.
- R7: Set and clear requests from different write lanes in the same cycle all take effect.
- R8: When a set and a clear target the same bit in the same cycle, the bit ends up set.
- R9: `rd_hazard_o[r]` is high only when `rd_flag_i[r]` is high and bit `src_i[r]` of `vec_o` is set. It is low whenever `rd_flag_i[r]` is low.
- R10: After any cycle in which `rd_busy_i[r]` is high and `rd_hazard_o[r]` is low, the lane reports no hazard until `rd_busy_i[r]` goes low.
- R11: `waw_o[p]` equals `wr_flag_i[p]` AND bit `dest_i[p]` of `vec_o`, whether or not `issue_i[p]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | NWP | Per-lane issue strobe |
| wr_flag_i | input | NWP | Instruction writes its destination |
| dest_i | input | NWP x IDW | Issue-time destination register number |
| busy_i | input | NWP | Function unit of the lane is busy |
| done_i | input | NWP | Function unit completes |
| data_ok_i | input | NWP | Result carries data to write |
| wr_en_i | input | NWP | Register file port write strobe |
| wr_addr_i | input | NWP x IDW | Register file port write address |
| rd_flag_i | input | NRD | Read lane has an active source |
| src_i | input | NRD x IDW | Source register number |
| rd_busy_i | input | NRD | Function unit of the read lane is busy |
| vec_o | output | NREG | Pending-write vector |
| rd_hazard_o | output | NRD | Read-after-write hazard per lane |
| waw_o | output | NWP | Write-after-write hazard per write lane |

## Verification
The bench builds the block with 16 binary-addressed registers, two write lanes and three read lanes. Two write lanes allow simultaneous sets, simultaneous clears, and a set racing a clear from another lane on one bit. Three read lanes let one lane hold its quiet state while others still report hazards. The small register count keeps every bit of the vector visible in each cycle's comparison against the reference model.

// File: rtl/wpsb_pkg.sv
package wpsb_pkg;
  // width of a register-number field: binary index or unary mask
  function automatic int id_width(int nreg, bit unary);
    if (unary) return nreg;
    return (nreg > 1) ? $clog2(nreg) : 1;
  endfunction
endpackage

// File: rtl/wpsb_onehot.sv
module wpsb_onehot #(
  parameter int NREG  = 32,
  parameter bit UNARY = 1'b0,
  parameter int IDW   = 5
) (
  input  logic [IDW-1:0]  num_i,
  output logic [NREG-1:0] mask_o
);
  generate
    if (UNARY) begin : g_unary
      assign mask_o = NREG'(num_i);
    end else begin : g_binary
      assign mask_o = NREG'(1) << num_i;
    end
  endgenerate
endmodule

// File: rtl/wpsb_vec.sv
module wpsb_vec #(
  parameter int NREG = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] set_i,
  input  logic [NREG-1:0] clr_i,
  output logic [NREG-1:0] vec_o
);
  logic [NREG-1:0] vec_q;

  // set has priority: it belongs to a newer instruction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= '0;
    else         vec_q <= (vec_q & ~clr_i) | set_i;
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/wpsb_wr_lane.sv
module wpsb_wr_lane #(
  parameter int NREG  = 32,
  parameter bit UNARY = 1'b0,
  parameter int IDW   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic            wr_flag_i,
  input  logic [IDW-1:0]  dest_i,
  input  logic            busy_i,
  input  logic            done_i,
  input  logic            data_ok_i,
  input  logic            wr_en_i,
  input  logic [IDW-1:0]  wr_addr_i,
  input  logic [NREG-1:0] vec_i,
  output logic [NREG-1:0] set_o,
  output logic [NREG-1:0] clr_o,
  output logic            waw_o
);
  logic [IDW-1:0]  dest_q;
  logic            set_q;
  logic            flag_q;
  logic [NREG-1:0] in_mask;
  logic [NREG-1:0] lat_mask;
  logic [NREG-1:0] port_mask;
  logic            no_write;

  wpsb_onehot #(.NREG(NREG), .UNARY(UNARY), .IDW(IDW)) u_in_dec (
    .num_i(dest_i), .mask_o(in_mask));
  wpsb_onehot #(.NREG(NREG), .UNARY(UNARY), .IDW(IDW)) u_lat_dec (
    .num_i(dest_q), .mask_o(lat_mask));
  wpsb_onehot #(.NREG(NREG), .UNARY(UNARY), .IDW(IDW)) u_port_dec (
    .num_i(wr_addr_i), .mask_o(port_mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_q <= '0;
      set_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      set_q <= issue_i & wr_flag_i;      // set lands one cycle after issue
      if (issue_i) begin
        dest_q <= dest_i;
        flag_q <= wr_flag_i;
      end else if (!busy_i) begin
        flag_q <= 1'b0;
      end
    end
  end

  // unit finished but will never write: release its destination
  assign no_write = done_i & flag_q & ~data_ok_i;

  assign set_o = set_q ? lat_mask : '0;
  assign clr_o = (wr_en_i ? port_mask : '0) | (no_write ? lat_mask : '0);
  // not gated by issue_i, avoiding a loop through the issue decision
  assign waw_o = wr_flag_i & (|(vec_i & in_mask));
endmodule

// File: rtl/wpsb_rd_lane.sv
module wpsb_rd_lane #(
  parameter int NREG  = 32,
  parameter bit UNARY = 1'b0,
  parameter int IDW   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_flag_i,
  input  logic [IDW-1:0]  src_i,
  input  logic            busy_i,
  input  logic [NREG-1:0] vec_i,
  output logic            hazard_o
);
  logic [NREG-1:0] src_mask;
  logic            quiet_q;
  logic            hazard;

  wpsb_onehot #(.NREG(NREG), .UNARY(UNARY), .IDW(IDW)) u_src_dec (
    .num_i(src_i), .mask_o(src_mask));

  assign hazard = rd_flag_i & ~quiet_q & (|(vec_i & src_mask));

  // a busy cycle without hazard silences the lane until busy drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      quiet_q <= 1'b0;
    else if (!busy_i) quiet_q <= 1'b0;
    else if (!hazard) quiet_q <= 1'b1;
  end

  assign hazard_o = hazard;
endmodule

// File: rtl/wpsb_scoreboard.sv
module wpsb_scoreboard #(
  parameter int NREG  = 32,
  parameter int NWP   = 3,
  parameter int NRD   = 4,
  parameter bit UNARY = 1'b0,
  localparam int IDW  = wpsb_pkg::id_width(NREG, UNARY)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NWP-1:0]           issue_i,
  input  logic [NWP-1:0]           wr_flag_i,
  input  logic [NWP-1:0][IDW-1:0]  dest_i,
  input  logic [NWP-1:0]           busy_i,
  input  logic [NWP-1:0]           done_i,
  input  logic [NWP-1:0]           data_ok_i,
  input  logic [NWP-1:0]           wr_en_i,
  input  logic [NWP-1:0][IDW-1:0]  wr_addr_i,
  input  logic [NRD-1:0]           rd_flag_i,
  input  logic [NRD-1:0][IDW-1:0]  src_i,
  input  logic [NRD-1:0]           rd_busy_i,
  output logic [NREG-1:0]          vec_o,
  output logic [NRD-1:0]           rd_hazard_o,
  output logic [NWP-1:0]           waw_o
);
  logic [NWP-1:0][NREG-1:0] set_lane;
  logic [NWP-1:0][NREG-1:0] clr_lane;
  logic [NREG-1:0]          set_any;
  logic [NREG-1:0]          clr_any;
  logic [NREG-1:0]          vec;

  for (genvar p = 0; p < NWP; p++) begin : g_wr
    wpsb_wr_lane #(.NREG(NREG), .UNARY(UNARY), .IDW(IDW)) u_wr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .issue_i  (issue_i[p]),
      .wr_flag_i(wr_flag_i[p]),
      .dest_i   (dest_i[p]),
      .busy_i   (busy_i[p]),
      .done_i   (done_i[p]),
      .data_ok_i(data_ok_i[p]),
      .wr_en_i  (wr_en_i[p]),
      .wr_addr_i(wr_addr_i[p]),
      .vec_i    (vec),
      .set_o    (set_lane[p]),
      .clr_o    (clr_lane[p]),
      .waw_o    (waw_o[p])
    );
  end

  // merge all lanes; no lane overrides another
  always_comb begin
    set_any = '0;
    clr_any = '0;
    for (int p = 0; p < NWP; p++) begin
      set_any |= set_lane[p];
      clr_any |= clr_lane[p];
    end
  end

  wpsb_vec #(.NREG(NREG)) u_vec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_any),
    .clr_i (clr_any),
    .vec_o (vec)
  );

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    wpsb_rd_lane #(.NREG(NREG), .UNARY(UNARY), .IDW(IDW)) u_rd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_flag_i(rd_flag_i[r]),
      .src_i    (src_i[r]),
      .busy_i   (rd_busy_i[r]),
      .vec_i    (vec),
      .hazard_o (rd_hazard_o[r])
    );
  end

  assign vec_o = vec;
endmodule

// File: rtl/wpsb_checker.sv
module wpsb_checker #(
  parameter int NREG  = 32,
  parameter int NWP   = 3,
  parameter int NRD   = 4,
  parameter bit UNARY = 1'b0,
  parameter int IDW   = 5
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NWP-1:0]           issue_i,
  input logic [NWP-1:0]           wr_flag_i,
  input logic [NWP-1:0][IDW-1:0]  dest_i,
  input logic [NWP-1:0]           wr_en_i,
  input logic [NWP-1:0][IDW-1:0]  wr_addr_i,
  input logic [NRD-1:0]           rd_flag_i,
  input logic [NRD-1:0][IDW-1:0]  src_i,
  input logic [NRD-1:0]           rd_busy_i,
  input logic [NREG-1:0]          vec_o,
  input logic [NRD-1:0]           rd_hazard_o,
  input logic [NWP-1:0]           waw_o
);
  function automatic logic [NREG-1:0] mk(input logic [IDW-1:0] n);
    return UNARY ? NREG'(n) : (NREG'(1) << n);
  endfunction

  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= |(issue_i & wr_flag_i);
  end

  for (genvar p = 0; p < NWP; p++) begin : g_wp
    a_r2_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_i[p] && wr_flag_i[p]) |=> ##1 (|(vec_o & mk($past(dest_i[p], 2)))));
    a_r4_clear_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i[p] && !pend_q) |=> !(|(vec_o & mk($past(wr_addr_i[p])))));
    a_r11_waw_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      waw_o[p] |-> (wr_flag_i[p] && (|(vec_o & mk(dest_i[p])))));
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rl
    a_r9_hazard_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_hazard_o[r] |-> (rd_flag_i[r] && (|(vec_o & mk(src_i[r])))));
    a_r10_lane_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((rd_busy_i[r] && !rd_hazard_o[r]) ##1 rd_busy_i[r]) |-> !rd_hazard_o[r]);
  end
endmodule

bind wpsb_scoreboard wpsb_checker #(
  .NREG(NREG), .NWP(NWP), .NRD(NRD), .UNARY(UNARY), .IDW(IDW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(issue_i), .wr_flag_i(wr_flag_i),
  .dest_i(dest_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .rd_flag_i(rd_flag_i), .src_i(src_i), .rd_busy_i(rd_busy_i),
  .vec_o(vec_o), .rd_hazard_o(rd_hazard_o), .waw_o(waw_o)
);

// File: tb/sim_wpsb_scoreboard.sv
module sim_wpsb_scoreboard;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;
  localparam int NWP  = 2;
  localparam int NRD  = 3;
  localparam int IDW  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NWP-1:0]          issue, wr_flag, busy, done, data_ok, wr_en;
  logic [NWP-1:0][IDW-1:0] dest, wr_addr;
  logic [NRD-1:0]          rd_flag, rd_busy;
  logic [NRD-1:0][IDW-1:0] src;
  logic [NREG-1:0]         vec_o;
  logic [NRD-1:0]          rd_hazard_o;
  logic [NWP-1:0]          waw_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpsb_scoreboard #(.NREG(NREG), .NWP(NWP), .NRD(NRD), .UNARY(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .issue_i(issue), .wr_flag_i(wr_flag),
    .dest_i(dest), .busy_i(busy), .done_i(done), .data_ok_i(data_ok),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .rd_flag_i(rd_flag), .src_i(src),
    .rd_busy_i(rd_busy), .vec_o(vec_o), .rd_hazard_o(rd_hazard_o), .waw_o(waw_o)
  );

  typedef struct {
    logic [NREG-1:0] vec;
    logic [NRD-1:0]  rdh;
    logic [NWP-1:0]  waw;
    string           tag;
  } exp_t;
  exp_t expq[$];

  // reference model state
  logic [NREG-1:0]         m_vec;
  logic [NWP-1:0]          m_iss, m_wf;
  logic [NWP-1:0][IDW-1:0] m_dq;
  logic [NRD-1:0]          m_rel;

  function automatic logic [NREG-1:0] oh(input logic [IDW-1:0] n);
    return NREG'(1) << n;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: expected outputs for the current inputs, then advance model
  task automatic step(input string tag);
    exp_t e;
    logic [NREG-1:0] s, c;
    s = '0; c = '0;
    for (int p = 0; p < NWP; p++) begin
      if (m_iss[p]) s |= oh(m_dq[p]);
      if (wr_en[p]) c |= oh(wr_addr[p]);
      if (done[p] && m_wf[p] && !data_ok[p]) c |= oh(m_dq[p]);
      e.waw[p] = wr_flag[p] && ((m_vec & oh(dest[p])) != 0);
    end
    for (int r = 0; r < NRD; r++)
      e.rdh[r] = rd_flag[r] && !m_rel[r] && ((m_vec & oh(src[r])) != 0);
    e.vec = m_vec;
    e.tag = tag;
    expq.push_back(e);
    m_vec = (m_vec & ~c) | s;
    for (int p = 0; p < NWP; p++) begin
      m_iss[p] = issue[p] && wr_flag[p];
      if (issue[p]) begin
        m_dq[p] = dest[p];
        m_wf[p] = wr_flag[p];
      end else if (!busy[p]) begin
        m_wf[p] = 1'b0;
      end
    end
    for (int r = 0; r < NRD; r++)
      m_rel[r] = rd_busy[r] ? (m_rel[r] || !e.rdh[r]) : 1'b0;
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        cmp(e.tag, "vec_o", 32'(vec_o), 32'(e.vec));
        cmp(e.tag, "rd_hazard_o", 32'(rd_hazard_o), 32'(e.rdh));
        cmp(e.tag, "waw_o", 32'(waw_o), 32'(e.waw));
      end
    end
  end

  task automatic pulses_off();
    issue = '0; wr_en = '0; done = '0; data_ok = '0;
  endtask

  initial begin
    pulses_off();
    wr_flag = '0; busy = '0; dest = '0; wr_addr = '0;
    rd_flag = '0; rd_busy = '0; src = '0;
    m_vec = '0; m_iss = '0; m_wf = '0; m_dq = '0; m_rel = '0;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    cmp("R1", "vec_o in reset", 32'(vec_o), 32'd0);
    cmp("R1", "hazards in reset", 32'({rd_hazard_o, waw_o}), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    step("R1");

    // R2: delayed set, no self-hazard in cycle after issue
    issue[0] = 1; wr_flag[0] = 1; dest[0] = 4'd5; busy[0] = 1;
    step("R2");
    pulses_off(); wr_flag[0] = 0;
    rd_flag[0] = 1; src[0] = 4'd5;
    step("R2");
    step("R9");
    rd_flag[0] = 0;
    step("R9");

    // R3: issue without write flag
    issue[1] = 1; wr_flag[1] = 0; dest[1] = 4'd7; busy[1] = 1;
    step("R3");
    pulses_off();
    step("R3");
    step("R3");

    // R4: port write clears
    wr_en[0] = 1; wr_addr[0] = 4'd5;
    step("R4");
    pulses_off();
    step("R4");

    // R5: data-less completion clears, data completion does not
    issue[1] = 1; wr_flag[1] = 1; dest[1] = 4'd9; busy[1] = 1;
    issue[0] = 1; wr_flag[0] = 1; dest[0] = 4'd3; busy[0] = 1;
    step("R5");
    pulses_off(); wr_flag = '0;
    step("R5");
    done[1] = 1; data_ok[1] = 0;
    done[0] = 1; data_ok[0] = 1;
    step("R5");
    pulses_off();
    step("R5");
    wr_en[1] = 1; wr_addr[1] = 4'd3;
    step("R4");
    pulses_off();
    step("R4");

    // R6: flag dropped when unit idle
    issue[0] = 1; wr_flag[0] = 1; dest[0] = 4'd4; busy[0] = 1;
    step("R6");
    pulses_off(); wr_flag[0] = 0;
    step("R6");
    busy[0] = 0;
    step("R6");
    done[0] = 1; data_ok[0] = 0;
    step("R6");
    pulses_off();
    step("R6");
    wr_en[0] = 1; wr_addr[0] = 4'd4;
    step("R6");
    pulses_off();
    step("R6");

    // R7: two lanes set, then two lanes clear, same cycle
    issue = 2'b11; wr_flag = 2'b11; dest[0] = 4'd10; dest[1] = 4'd11; busy = 2'b11;
    step("R7");
    pulses_off(); wr_flag = '0;
    step("R7");
    step("R7");
    wr_en = 2'b11; wr_addr[0] = 4'd10; wr_addr[1] = 4'd11;
    step("R7");
    pulses_off();
    step("R7");

    // R8: set and clear on one bit in one cycle
    issue[0] = 1; wr_flag[0] = 1; dest[0] = 4'd12;
    step("R8");
    pulses_off(); wr_flag[0] = 0;
    step("R8");
    issue[0] = 1; wr_flag[0] = 1; dest[0] = 4'd12;
    step("R8");
    pulses_off(); wr_flag[0] = 0;
    wr_en[1] = 1; wr_addr[1] = 4'd12;
    step("R8");
    pulses_off();
    step("R8");

    // R11: WAW independent of issue
    wr_flag[1] = 1; dest[1] = 4'd12;
    step("R11");
    dest[1] = 4'd13;
    step("R11");
    wr_flag[1] = 0; dest[1] = 4'd12;
    step("R11");

    // R10: lane quiet after busy cycle without hazard
    rd_flag[1] = 1; src[1] = 4'd12; rd_busy[1] = 1;
    rd_flag[2] = 1; src[2] = 4'd12;
    step("R10");
    step("R10");
    wr_en[0] = 1; wr_addr[0] = 4'd12;
    step("R10");
    pulses_off();
    step("R10");
    issue[1] = 1; wr_flag[1] = 1; dest[1] = 4'd12;
    step("R10");
    pulses_off(); wr_flag[1] = 0;
    step("R10");
    step("R10");
    step("R10");
    rd_busy[1] = 0;
    step("R10");
    step("R10");
    rd_flag = '0;
    step("R9");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule